// File: doc/BRIEF.md
# Flash Program/Erase Status Register

This block holds the status byte of a NOR-style flash command interface, together with a simplified model of the program/erase engine that drives it. Single-cycle command strobes start a program or an erase, suspend or resume the running operation, clear the error flags, or select what a read returns. The block reports an 8-bit status byte and a flag that tells the read path whether to return that byte or array data. The status byte does not depend on the address, so a read at any address returns it.

A program runs for a fixed number of cycles and samples the verify result in its last cycle. An erase runs as a series of fixed-length pulses. It checks the verify result at the end of each pulse and gives up after a set maximum number of pulses. Three error flags record a failed erase, a failed program or unlock-code check, and an attempt made while the supply-enable level was low. These flags stay set until a clear command or a reset. While any of them is set, a new program or erase is refused and reported as failed.

Top module: `flash_status_ctl`

## Requirements
- R1: After reset the status byte reads 0x80 and show_status is 0. Status bits 2..0 always read 0.
- R2: Status bit 7 reads 0 exactly while an operation runs. A program keeps it at 0 for PROG_CYCLES sampled cycles after the command edge. An erase keeps it at 0 for PULSE_CYCLES cycles per pulse used.
- R3: An erase ends after the first pulse whose verify passes. If verify still fails after ERASE_PULSES pulses, the erase ends and status bit 5 is set.
- R4: Status bit 4 is set when a program's verify fails in its last cycle, or when an unlock strobe arrives with unlock_ok low.
- R5: A program or erase issued while supply_en is low does not start: bit 7 stays 1. In the same cycle bit 3 is set, together with bit 4 for a program or bit 5 for an erase.
- R6: Bits 5, 4 and 3 stay set, including across array-read mode and refused commands, until a clear strobe or a reset clears them.
- R7: While any of bits 5..3 is set, a new program or erase does not start: bit 7 stays 1, and its own failure bit (4 for a program, 5 for an erase) is set.
- R8: After a suspend strobe, bit 7 stays 0 for SUSPEND_LAT more cycles. The engine then pauses and the status reads bit 7 = 1 and bit 6 = 1. A resume strobe returns bits 7 and 6 to 0, and the operation continues to its normal result.
- R9: If the operation completes before the suspend latency runs out, it finishes normally: bit 7 goes to 1 and bit 6 stays 0.
- R10: Status bit 6 reads 0 whenever bit 7 reads 0.
- R11: A program, erase, unlock, resume or read-status strobe sets show_status to 1. A read-array strobe with none of those clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_program | input | 1 | Program command strobe |
| cmd_erase | input | 1 | Erase command strobe |
| cmd_suspend | input | 1 | Suspend request strobe |
| cmd_resume | input | 1 | Resume command strobe |
| cmd_clear | input | 1 | Clear error flags strobe |
| cmd_read_status | input | 1 | Select status output |
| cmd_read_array | input | 1 | Select array output |
| cmd_unlock | input | 1 | Protection-unlock code check strobe |
| unlock_ok | input | 1 | Result of the unlock code check |
| supply_en | input | 1 | Program/erase supply-enable level |
| verify_pass | input | 1 | Engine verify result |
| status_byte | output | 8 | Status byte |
| show_status | output | 1 | 1: reads return status, 0: array data |

## Verification
The hardest case to reach is the race between a suspend and the operation's own end. The suspend strobe has to land at a chosen point in the engine's countdown. The stimulus counts clock edges from the command edge and issues the suspend either in the middle of an erase pulse sequence, which must pause, or one cycle before a program's final cycle, which must finish with bit 6 never set. The refusal path needs a sticky flag left over from an earlier failed operation, so the bench fails an operation on purpose, switches to array reads, and then issues new commands.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_RUN  = 2'd1,
        ENG_HOLD = 2'd2
    } eng_state_e;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_kind_e;

    // error flag order matches status bits 5..3
    typedef struct packed {
        logic erase_fail;
        logic prog_fail;
        logic supply_low;
    } err_flags_t;

endpackage

// File: rtl/flash_sr_engine.sv
module flash_sr_engine
    import flash_sr_pkg::*;
#(
    parameter int PROG_CYCLES  = 8,
    parameter int PULSE_CYCLES = 3,
    parameter int ERASE_PULSES = 4,
    parameter int SUSPEND_LAT  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_program,
    input  logic cmd_erase,
    input  logic cmd_suspend,
    input  logic cmd_resume,
    input  logic supply_en,
    input  logic verify_pass,
    input  logic err_pending,
    output logic busy,
    output logic held,
    output logic ev_prog_fail,
    output logic ev_erase_fail,
    output logic ev_supply_low
);

    localparam int MAX_SEG = (PROG_CYCLES > PULSE_CYCLES) ? PROG_CYCLES : PULSE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_SEG + 1);
    localparam int PUL_W   = $clog2(ERASE_PULSES + 1);
    localparam int SL_W    = $clog2(SUSPEND_LAT + 1);

    typedef struct packed {
        eng_state_e       st;
        op_kind_e         op;
        logic [CNT_W-1:0] cnt;
        logic [PUL_W-1:0] pulse;
        logic             pend;
        logic [SL_W-1:0]  scnt;
    } eng_regs_t;

    eng_regs_t eng_d, eng_q;

    logic want_prog, want_erase, seg_end, finish;

    always_comb begin
        eng_d         = eng_q;
        ev_prog_fail  = 1'b0;
        ev_erase_fail = 1'b0;
        ev_supply_low = 1'b0;
        want_prog     = cmd_program;
        want_erase    = cmd_erase & ~cmd_program;
        seg_end       = (eng_q.cnt == '0);
        finish        = seg_end && (eng_q.op == OP_PROG || verify_pass ||
                        eng_q.pulse == PUL_W'(ERASE_PULSES - 1));
        unique case (eng_q.st)
            ENG_IDLE: begin
                if (want_prog || want_erase) begin
                    if (!supply_en) begin
                        ev_supply_low = 1'b1;
                        ev_prog_fail  = want_prog;
                        ev_erase_fail = want_erase;
                    end else if (err_pending) begin
                        ev_prog_fail  = want_prog;
                        ev_erase_fail = want_erase;
                    end else begin
                        eng_d.st    = ENG_RUN;
                        eng_d.op    = want_erase ? OP_ERASE : OP_PROG;
                        eng_d.cnt   = want_erase ? CNT_W'(PULSE_CYCLES - 1)
                                                 : CNT_W'(PROG_CYCLES - 1);
                        eng_d.pulse = '0;
                        eng_d.pend  = 1'b0;
                        eng_d.scnt  = '0;
                    end
                end
            end
            ENG_RUN: begin
                if (finish) begin
                    eng_d.st   = ENG_IDLE;
                    eng_d.pend = 1'b0;
                    if (eng_q.op == OP_PROG) begin
                        ev_prog_fail = ~verify_pass;
                    end else begin
                        ev_erase_fail = ~verify_pass;
                    end
                end else if (eng_q.pend && eng_q.scnt == '0) begin
                    eng_d.st   = ENG_HOLD;
                    eng_d.pend = 1'b0;
                end else begin
                    if (seg_end) begin
                        eng_d.pulse = eng_q.pulse + 1'b1;
                        eng_d.cnt   = CNT_W'(PULSE_CYCLES - 1);
                    end else begin
                        eng_d.cnt = eng_q.cnt - 1'b1;
                    end
                    if (eng_q.pend) begin
                        eng_d.scnt = eng_q.scnt - 1'b1;
                    end else if (cmd_suspend) begin
                        eng_d.pend = 1'b1;
                        eng_d.scnt = SL_W'(SUSPEND_LAT - 1);
                    end
                end
            end
            ENG_HOLD: begin
                if (cmd_resume) begin
                    eng_d.st = ENG_RUN;
                end
            end
            default: eng_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{st: ENG_IDLE, op: OP_PROG, default: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign busy = (eng_q.st == ENG_RUN);
    assign held = (eng_q.st == ENG_HOLD);

    assert_lowsupply_no_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !held && (cmd_program || cmd_erase) && !supply_en) |=> !busy);

    assert_refuse_on_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !held && (cmd_program || cmd_erase) && err_pending) |=> !busy);

    assert_resume_runs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (held && cmd_resume) |=> busy);

    assert_hold_waits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !cmd_resume) |=> held);

    assert_pulse_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (eng_q.pulse < PUL_W'(ERASE_PULSES)));

endmodule

// File: rtl/flash_sr_sticky.sv
module flash_sr_sticky
    import flash_sr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       set_erase,
    input  logic       set_prog,
    input  logic       set_supply,
    output err_flags_t flags,
    output logic       any_set
);

    err_flags_t flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (clear) begin
            flags_d = '0;
        end
        flags_d.erase_fail = flags_d.erase_fail | set_erase;
        flags_d.prog_fail  = flags_d.prog_fail  | set_prog;
        flags_d.supply_low = flags_d.supply_low | set_supply;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags   = flags_q;
    assign any_set = |flags_q;

    assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

endmodule

// File: rtl/flash_sr_readmode.sv
module flash_sr_readmode (
    input  logic clk,
    input  logic rst_n,
    input  logic to_status,
    input  logic to_array,
    output logic show_status
);

    logic show_d, show_q;

    always_comb begin
        show_d = show_q;
        if (to_status) begin
            show_d = 1'b1;
        end else if (to_array) begin
            show_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            show_q <= 1'b0;
        end else begin
            show_q <= show_d;
        end
    end

    assign show_status = show_q;

    assert_status_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
        to_status |=> show_status);

    assert_array_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (to_array && !to_status) |=> !show_status);

endmodule

// File: rtl/flash_status_ctl.sv
module flash_status_ctl
    import flash_sr_pkg::*;
#(
    parameter int PROG_CYCLES  = 8,
    parameter int PULSE_CYCLES = 3,
    parameter int ERASE_PULSES = 4,
    parameter int SUSPEND_LAT  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_program,
    input  logic       cmd_erase,
    input  logic       cmd_suspend,
    input  logic       cmd_resume,
    input  logic       cmd_clear,
    input  logic       cmd_read_status,
    input  logic       cmd_read_array,
    input  logic       cmd_unlock,
    input  logic       unlock_ok,
    input  logic       supply_en,
    input  logic       verify_pass,
    output logic [7:0] status_byte,
    output logic       show_status
);

    logic       busy, held;
    logic       ev_prog_fail, ev_erase_fail, ev_supply_low;
    logic       err_any;
    err_flags_t err;

    flash_sr_engine #(
        .PROG_CYCLES (PROG_CYCLES),
        .PULSE_CYCLES(PULSE_CYCLES),
        .ERASE_PULSES(ERASE_PULSES),
        .SUSPEND_LAT (SUSPEND_LAT)
    ) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_program  (cmd_program),
        .cmd_erase    (cmd_erase),
        .cmd_suspend  (cmd_suspend),
        .cmd_resume   (cmd_resume),
        .supply_en    (supply_en),
        .verify_pass  (verify_pass),
        .err_pending  (err_any),
        .busy         (busy),
        .held         (held),
        .ev_prog_fail (ev_prog_fail),
        .ev_erase_fail(ev_erase_fail),
        .ev_supply_low(ev_supply_low)
    );

    flash_sr_sticky u_sticky (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cmd_clear),
        .set_erase (ev_erase_fail),
        .set_prog  (ev_prog_fail | (cmd_unlock & ~unlock_ok)),
        .set_supply(ev_supply_low),
        .flags     (err),
        .any_set   (err_any)
    );

    flash_sr_readmode u_readmode (
        .clk        (clk),
        .rst_n      (rst_n),
        .to_status  (cmd_program | cmd_erase | cmd_unlock | cmd_resume | cmd_read_status),
        .to_array   (cmd_read_array),
        .show_status(show_status)
    );

    // bit7 idle (active-low busy), bit6 paused, bits5..3 sticky errors
    assign status_byte = {~busy, held & ~busy, err.erase_fail, err.prog_fail,
                          err.supply_low, 3'b000};

endmodule

// File: tb/flash_status_ctl_tb.sv
`timescale 1ns/1ps
module flash_status_ctl_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_program = 0, cmd_erase = 0, cmd_suspend = 0, cmd_resume = 0;
    logic cmd_clear = 0, cmd_read_status = 0, cmd_read_array = 0, cmd_unlock = 0;
    logic unlock_ok = 1, supply_en = 1, verify_pass = 1;
    logic [7:0] status_byte;
    logic show_status;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    flash_status_ctl u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_program(cmd_program), .cmd_erase(cmd_erase),
        .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume),
        .cmd_clear(cmd_clear), .cmd_read_status(cmd_read_status),
        .cmd_read_array(cmd_read_array), .cmd_unlock(cmd_unlock),
        .unlock_ok(unlock_ok), .supply_en(supply_en), .verify_pass(verify_pass),
        .status_byte(status_byte), .show_status(show_status)
    );

    localparam int C_PROG = 0, C_ERASE = 1, C_SUSP = 2, C_RES = 3, C_CLR = 4;
    localparam int C_RSTAT = 5, C_RARR = 6, C_UNLK = 7;

    // {is_erase, supply_en, verify_pass, expected status, expected busy cycles}
    localparam logic [18:0] VEC [6] = '{
        {1'b0, 1'b1, 1'b1, 8'h80, 8'd8},
        {1'b0, 1'b1, 1'b0, 8'h90, 8'd8},
        {1'b1, 1'b1, 1'b1, 8'h80, 8'd3},
        {1'b1, 1'b1, 1'b0, 8'hA0, 8'd12},
        {1'b0, 1'b0, 1'b1, 8'h98, 8'd0},
        {1'b1, 1'b0, 1'b1, 8'hA8, 8'd0}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // called at a negedge; strobe is seen at the following posedge
    task automatic send(input int code);
        case (code)
            C_PROG:  cmd_program     = 1'b1;
            C_ERASE: cmd_erase       = 1'b1;
            C_SUSP:  cmd_suspend     = 1'b1;
            C_RES:   cmd_resume      = 1'b1;
            C_CLR:   cmd_clear       = 1'b1;
            C_RSTAT: cmd_read_status = 1'b1;
            C_RARR:  cmd_read_array  = 1'b1;
            default: cmd_unlock      = 1'b1;
        endcase
        @(negedge clk);
        cmd_program = 0; cmd_erase = 0; cmd_suspend = 0; cmd_resume = 0;
        cmd_clear = 0; cmd_read_status = 0; cmd_read_array = 0; cmd_unlock = 0;
    endtask

    // counts samples with bit7 low; flags any bit6 seen while busy (R10)
    task automatic wait_idle(output int n);
        n = 0;
        while (status_byte[7] == 1'b0 && n < 400) begin
            if (status_byte[6]) check("R10 bit6 while busy", status_byte[6], 0);
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #1000000;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 status after reset", status_byte, 8'h80);
        check("R1 show_status after reset", show_status, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table of basic operations: R2 R3 R4 R5 R11
        for (int i = 0; i < 6; i++) begin
            send(C_CLR);
            supply_en   = VEC[i][17];
            verify_pass = VEC[i][16];
            send(VEC[i][18] ? C_ERASE : C_PROG);
            wait_idle(n);
            check("R2 busy cycles", n, VEC[i][7:0]);
            check("R3 R4 R5 final status", status_byte, VEC[i][15:8]);
            check("R11 auto status mode", show_status, 1);
            check("R1 reserved bits", status_byte[2:0], 0);
        end
        supply_en = 1'b1;

        // R6 / R7: sticky flags and refusal
        send(C_CLR);
        verify_pass = 1'b0;
        send(C_PROG);
        wait_idle(n);
        send(C_RARR);
        check("R11 array mode", show_status, 0);
        check("R6 sticky across array read", status_byte, 8'h90);
        verify_pass = 1'b1;
        send(C_PROG);
        check("R7 program refused", status_byte, 8'h90);
        check("R11 program sets status mode", show_status, 1);
        send(C_ERASE);
        check("R7 erase refused sets bit5", status_byte, 8'hB0);
        repeat (4) @(negedge clk);
        check("R6 flags hold", status_byte, 8'hB0);
        send(C_CLR);
        check("R6 clear", status_byte, 8'h80);

        // R8: suspend mid-erase and resume
        verify_pass = 1'b0;
        send(C_ERASE);
        repeat (3) @(negedge clk);
        send(C_SUSP);
        check("R8 busy after suspend", status_byte[7], 0);
        @(negedge clk);
        check("R8 busy during latency", status_byte[7], 0);
        @(negedge clk);
        check("R8 paused status", status_byte, 8'hC0);
        send(C_RARR);
        repeat (3) @(negedge clk);
        check("R8 stays paused", status_byte, 8'hC0);
        send(C_RES);
        check("R8 resume clears bit6", status_byte, 8'h00);
        check("R11 resume sets status mode", show_status, 1);
        wait_idle(n);
        check("R8 resumed erase result", status_byte, 8'hA0);
        send(C_CLR);

        // R9: suspend too late, operation finishes
        verify_pass = 1'b1;
        send(C_PROG);
        repeat (5) @(negedge clk);
        send(C_SUSP);
        wait_idle(n);
        check("R9 finished not suspended", status_byte, 8'h80);
        repeat (3) @(negedge clk);
        check("R9 bit6 stays 0", status_byte, 8'h80);

        // R4 unlock check and R11 read commands
        send(C_RARR);
        unlock_ok = 1'b1;
        send(C_UNLK);
        check("R4 unlock ok", status_byte, 8'h80);
        check("R11 unlock sets status mode", show_status, 1);
        unlock_ok = 1'b0;
        send(C_UNLK);
        check("R4 unlock fail sets bit4", status_byte, 8'h90);
        send(C_RARR);
        send(C_RSTAT);
        check("R11 read-status", show_status, 1);

        // R1: reset clears sticky flags
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears flags", status_byte, 8'h80);
        check("R1 reset read mode", show_status, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule